// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block sends a stream of pixel words to a display panel that keeps its own frame memory. The link is a parallel bus driven in the style of a CPU write port. Each word is placed on a data bus, framed by an active-low chip select, and latched by the panel on an active-low write strobe. The chip-select lead-in, the strobe lead-in, the strobe width and the data hold after the strobe are four separate counts. Each count is programmed in a timing word.

A frame is a programmed number of words, width times height. A frame transfer begins only on a trigger. The trigger is either a software command or a rising edge on the tearing-effect line. That line comes from the panel and is assumed synchronous to `clk`. While a frame is in flight the block is busy, and every further trigger is thrown away, because a repeated trigger can upset the panel. At the end of a frame the block issues a one-clock done pulse, which serves as the frame-done interrupt, and leaves the busy state.

The pixel source is a valid/ready stream. The configuration words are taken as plain levels from a register file kept elsewhere.

Top module: `i80_write_seq`

## Requirements
- R1: The phase counts sit in the timing word as 4-bit fields: chip-select lead-in at bits 19:16, strobe lead-in at 15:12, strobe active at 11:8 and hold at 7:4. A field value n makes its phase last n+1 clocks. The phases run in this order: `cs_n` falls, (css+1)+(wrs+1) clocks later `wr_n` goes low for act+1 clocks, `wr_n` then stays high for hld+1 clocks with `cs_n` still low, and then `cs_n` returns high.
- R2: Each word holds `cs_n` low for exactly css+wrs+act+hld+4 clocks, so a phase programmed to zero still takes one clock.
- R3: During the whole low time of `cs_n`, `db` carries the accepted word unchanged. `wr_n` is low only while `cs_n` is low. Between words and when idle, `cs_n` is high for at least one clock.
- R4: A frame moves exactly `frame_w`×`frame_h` words, with both values taken at the trigger. After the last word, `frame_done` is high for exactly one clock, and in that same clock `busy` is low. A size of zero ends with the done pulse and no write cycle. No write cycle occurs while `busy` is low.
- R5: Bit 0 of the timing word enables the interface. While it is 0, no frame starts and no write cycle is issued, and an accepted software command stays pending. The frame starts once the bit is set.
- R6: Bit 0 of the trigger word enables triggering. While it is 0, a software command pulse is not recorded and no frame starts.
- R7: A pulse on `sw_trig_wr` sets the command bit `sw_trig_bit`. In software mode the frame starts on the next clock, and `sw_trig_bit` clears in the same clock that `busy` rises.
- R8: With trigger-word bit 3 set, bit 4 clear and bit 31 set, every rising edge of `te_in` while idle starts a frame, and software commands are not needed.
- R9: With bit 3 set and bits 4 and 31 clear, a `te_in` edge starts a frame only while a software command is pending. A command with no edge stays pending and starts nothing.
- R10: With bit 4 set, `te_in` has no effect, and software commands start frames directly.
- R11: Software pulses and `te_in` edges that arrive while `busy` is high are dropped. This includes the clock in which the frame completes. A dropped pulse leaves `sw_trig_bit` at 0 and causes no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_cfg | input | 32 | Enable bit and the four phase counts |
| trig_cfg | input | 32 | Trigger mode, hardware enable, mask and every-edge bits |
| sw_trig_wr | input | 1 | One-clock software trigger command |
| te_in | input | 1 | Tearing-effect line from the panel |
| frame_w | input | DIMW | Frame width in words |
| frame_h | input | DIMW | Frame height in lines |
| px_valid | input | 1 | Pixel word available |
| px_data | input | DW | Pixel word |
| px_ready | output | 1 | Pixel word taken this clock |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| db | output | DW | Panel data bus |
| busy | output | 1 | Frame transfer in progress |
| frame_done | output | 1 | One-clock end-of-frame interrupt |
| sw_trig_bit | output | 1 | Pending software command bit |

## Verification
Two events can land in the same clock: the completion of a frame and the arrival of a new trigger. The bench watches for `cs_n` rising after the last word of a frame. It then places a software pulse, and in a second run a `te_in` edge, so that the trigger is sampled on exactly the edge that raises `frame_done`. The trigger must be dropped: `frame_done` pulses, `sw_trig_bit` reads 0 on the next clock, and `busy` stays low for several clocks after that. Separately, the phase timing is swept over every combination of four counts drawn from {0,1,2,15}, and each word's low time, strobe offset, strobe width and data are compared with the arithmetic.

// File: rtl/i80_seq_pkg.sv
package i80_seq_pkg;

  localparam int PH_CNT_W = 4;

  localparam int TC_EN       = 0;
  localparam int TC_HLD_LSB  = 4;
  localparam int TC_ACT_LSB  = 8;
  localparam int TC_WRS_LSB  = 12;
  localparam int TC_CSS_LSB  = 16;

  localparam int TG_MODE     = 0;
  localparam int TG_HW_EN    = 3;
  localparam int TG_HW_MASK  = 4;
  localparam int TG_EVERY_TE = 31;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CSS  = 3'd1,
    PH_WRS  = 3'd2,
    PH_ACT  = 3'd3,
    PH_HLD  = 3'd4
  } phase_e;

  typedef struct packed {
    logic [PH_CNT_W-1:0] css;
    logic [PH_CNT_W-1:0] wrs;
    logic [PH_CNT_W-1:0] act;
    logic [PH_CNT_W-1:0] hld;
  } cyc_timing_t;

endpackage

// File: rtl/i80_trig_ctrl.sv
module i80_trig_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mode_en,
  input  logic hw_en,
  input  logic hw_mask,
  input  logic every_te,
  input  logic if_en,
  input  logic sw_wr,
  input  logic te_in,
  input  logic busy,
  output logic start,
  output logic sw_pend
);

  logic te_q;
  logic te_rise;
  logic hw_path;
  logic fire;

  assign te_rise = te_in & ~te_q;
  assign hw_path = hw_en & ~hw_mask;
  assign fire    = hw_path ? (te_rise & (every_te | sw_pend)) : sw_pend;
  assign start   = fire & mode_en & if_en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      te_q    <= 1'b0;
      sw_pend <= 1'b0;
    end else begin
      te_q <= te_in;
      if (start)
        sw_pend <= 1'b0;
      else if (sw_wr && mode_en && !busy)
        sw_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/i80_cycle_engine.sv
module i80_cycle_engine
  import i80_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_timing_t   tim,
  input  logic          word_go,
  input  logic [DW-1:0] word_in,
  output logic          idle,
  output logic          cs_n,
  output logic          wr_n,
  output logic [DW-1:0] db
);

  phase_e              st, st_nxt;
  logic [PH_CNT_W-1:0] tmr, tmr_nxt, lim;
  logic                last;

  always_comb begin
    case (st)
      PH_CSS:  lim = tim.css;
      PH_WRS:  lim = tim.wrs;
      PH_ACT:  lim = tim.act;
      PH_HLD:  lim = tim.hld;
      default: lim = '0;
    endcase
  end

  assign last = (tmr == lim);
  assign idle = (st == PH_IDLE);

  always_comb begin
    st_nxt  = st;
    tmr_nxt = tmr;
    if (st == PH_IDLE) begin
      if (word_go) begin
        st_nxt  = PH_CSS;
        tmr_nxt = '0;
      end
    end else if (last) begin
      tmr_nxt = '0;
      case (st)
        PH_CSS:  st_nxt = PH_WRS;
        PH_WRS:  st_nxt = PH_ACT;
        PH_ACT:  st_nxt = PH_HLD;
        default: st_nxt = PH_IDLE;
      endcase
    end else begin
      tmr_nxt = tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PH_IDLE;
      tmr  <= '0;
      cs_n <= 1'b1;
      wr_n <= 1'b1;
      db   <= '0;
    end else begin
      st   <= st_nxt;
      tmr  <= tmr_nxt;
      cs_n <= (st_nxt == PH_IDLE);
      wr_n <= (st_nxt != PH_ACT);
      if (st == PH_IDLE && word_go)
        db <= word_in;
    end
  end

endmodule

// File: rtl/i80_frame_ctrl.sv
module i80_frame_ctrl
  import i80_seq_pkg::*;
#(
  parameter int DIMW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [DIMW-1:0] fw,
  input  logic [DIMW-1:0] fh,
  input  cyc_timing_t     tim_in,
  input  logic            if_en,
  input  logic            eng_idle,
  input  logic            px_valid,
  output logic            busy,
  output logic            frame_done,
  output logic            px_ready,
  output logic            word_go,
  output cyc_timing_t     tim_q
);

  localparam int CNTW = 2 * DIMW;

  logic [CNTW-1:0] left;
  logic            empty;

  assign empty    = (left == '0);
  assign px_ready = busy & eng_idle & if_en & ~empty;
  assign word_go  = px_ready & px_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      frame_done <= 1'b0;
      left       <= '0;
      tim_q      <= '0;
    end else begin
      frame_done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        left  <= CNTW'(fw) * CNTW'(fh);
        tim_q <= tim_in;
      end else if (busy) begin
        if (word_go) begin
          left <= left - CNTW'(1);
        end else if (eng_idle && empty) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i80_write_seq.sv
module i80_write_seq
  import i80_seq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int DIMW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     timing_cfg,
  input  logic [31:0]     trig_cfg,
  input  logic            sw_trig_wr,
  input  logic            te_in,
  input  logic [DIMW-1:0] frame_w,
  input  logic [DIMW-1:0] frame_h,
  input  logic            px_valid,
  input  logic [DW-1:0]   px_data,
  output logic            px_ready,
  output logic            cs_n,
  output logic            wr_n,
  output logic [DW-1:0]   db,
  output logic            busy,
  output logic            frame_done,
  output logic            sw_trig_bit
);

  cyc_timing_t tim_live, tim_run;
  logic        if_en;
  logic        start;
  logic        eng_idle;
  logic        word_go;
  logic        unused_cfg;

  assign if_en    = timing_cfg[TC_EN];
  assign tim_live = {timing_cfg[TC_CSS_LSB +: PH_CNT_W],
                     timing_cfg[TC_WRS_LSB +: PH_CNT_W],
                     timing_cfg[TC_ACT_LSB +: PH_CNT_W],
                     timing_cfg[TC_HLD_LSB +: PH_CNT_W]};
  assign unused_cfg = ^{timing_cfg[31:20], timing_cfg[3:1],
                        trig_cfg[30:5], trig_cfg[2:1]};

  i80_trig_ctrl u_trig (
    .clk      (clk),
    .rst      (rst),
    .mode_en  (trig_cfg[TG_MODE]),
    .hw_en    (trig_cfg[TG_HW_EN]),
    .hw_mask  (trig_cfg[TG_HW_MASK]),
    .every_te (trig_cfg[TG_EVERY_TE]),
    .if_en    (if_en),
    .sw_wr    (sw_trig_wr),
    .te_in    (te_in),
    .busy     (busy),
    .start    (start),
    .sw_pend  (sw_trig_bit)
  );

  i80_frame_ctrl #(.DIMW(DIMW)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .fw         (frame_w),
    .fh         (frame_h),
    .tim_in     (tim_live),
    .if_en      (if_en),
    .eng_idle   (eng_idle),
    .px_valid   (px_valid),
    .busy       (busy),
    .frame_done (frame_done),
    .px_ready   (px_ready),
    .word_go    (word_go),
    .tim_q      (tim_run)
  );

  i80_cycle_engine #(.DW(DW)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .tim     (tim_run),
    .word_go (word_go),
    .word_in (px_data),
    .idle    (eng_idle),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .db      (db)
  );

endmodule

// File: rtl/i80_write_seq_chk.sv
module i80_write_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   timing_cfg,
  input logic [31:0]   trig_cfg,
  input logic          cs_n,
  input logic          wr_n,
  input logic [DW-1:0] db,
  input logic          busy,
  input logic          frame_done,
  input logic          sw_trig_bit
);

  AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !cs_n); // R3

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(db)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R4

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy); // R4

  AST_NO_CYCLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n); // R4

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(timing_cfg[0])); // R5

  AST_START_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(trig_cfg[0])); // R6

  AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !sw_trig_bit); // R7

  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> frame_done); // R11

endmodule

bind i80_write_seq i80_write_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/i80_write_seq_test.sv
`timescale 1ns/1ps
module i80_write_seq_test;

  localparam int DW   = 16;
  localparam int DIMW = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     timing_cfg = '0;
  logic [31:0]     trig_cfg = '0;
  logic            sw_trig_wr = 1'b0;
  logic            te_in = 1'b0;
  logic [DIMW-1:0] frame_w = '0;
  logic [DIMW-1:0] frame_h = '0;
  logic            px_valid = 1'b0;
  logic [DW-1:0]   px_data;
  logic            px_ready;
  logic            cs_n;
  logic            wr_n;
  logic [DW-1:0]   db;
  logic            busy;
  logic            frame_done;
  logic            sw_trig_bit;

  int n_chk = 0;
  int n_err = 0;
  int e_tot = 4, e_off = 2, e_len = 1;
  int tx = 0, rx = 0;
  logic [DW-1:0] sent [0:63];
  bit adv = 0;

  int low_cnt = 0, wr_off = 0, wr_len = 0;
  bit db_bad = 0;
  logic [DW-1:0] first_db;

  always #2 clk = ~clk;

  i80_write_seq #(.DW(DW), .DIMW(DIMW)) uut (
    .clk(clk), .rst(rst), .timing_cfg(timing_cfg), .trig_cfg(trig_cfg),
    .sw_trig_wr(sw_trig_wr), .te_in(te_in), .frame_w(frame_w), .frame_h(frame_h),
    .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
    .cs_n(cs_n), .wr_n(wr_n), .db(db), .busy(busy), .frame_done(frame_done),
    .sw_trig_bit(sw_trig_bit)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 613 + 17) ^ 16'h5A3C;
  endfunction

  function automatic int tv(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 15;
    endcase
  endfunction

  task automatic check_eq(input string rid, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rid, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial px_data = pat(0);

  // pixel source: record each accepted word, move to the next one a clock later
  always @(negedge clk) begin
    if (adv) begin
      px_data = pat(tx);
      adv = 0;
    end
    if (px_valid && px_ready) begin
      sent[tx % 64] = px_data;
      tx++;
      adv = 1;
    end
  end

  // bus monitor: measure every write cycle against the programmed counts
  always @(negedge clk) begin
    if (!rst && !cs_n) begin
      if (low_cnt == 0) first_db = db;
      if (!wr_n) begin
        if (wr_len == 0) wr_off = low_cnt;
        wr_len++;
      end
      if (db !== first_db) db_bad = 1;
      low_cnt++;
    end else if (!rst && low_cnt != 0) begin
      check_eq("R2", "select low clocks", low_cnt, e_tot);
      check_eq("R1", "strobe offset", wr_off, e_off);
      check_eq("R1", "strobe width", wr_len, e_len);
      check_eq("R3", "data word", first_db, sent[rx % 64]);
      check_eq("R3", "data held", db_bad, 0);
      rx++;
      low_cnt = 0; wr_off = 0; wr_len = 0; db_bad = 0;
    end
  end

  task automatic set_timing(input int c, input int s, input int a, input int h, input bit en);
    timing_cfg = (32'(c) << 16) | (32'(s) << 12) | (32'(a) << 8) | (32'(h) << 4) | 32'(en);
    e_tot = c + s + a + h + 4;
    e_off = c + s + 2;
    e_len = a + 1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw();
    sw_trig_wr = 1'b1;
    @(negedge clk);
    sw_trig_wr = 1'b0;
  endtask

  task automatic pulse_te();
    te_in = 1'b1;
    @(negedge clk);
    te_in = 1'b0;
  endtask

  task automatic wait_done(input string rid);
    int k = 0;
    while (!frame_done && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check_eq(rid, "done pulse seen", frame_done, 1);
  endtask

  task automatic run_frame(input int c, input int s, input int a, input int h,
                           input int w, input int hh, input string rid);
    int rx0;
    set_timing(c, s, a, h, 1'b1);
    frame_w = DIMW'(w);
    frame_h = DIMW'(hh);
    trig_cfg = 32'h1;
    rx0 = rx;
    pulse_sw();
    @(negedge clk);
    check_eq(rid, "busy after start", busy, 1);
    wait_done(rid);
    check_eq("R4", "words per frame", rx - rx0, w * hh);
    check_eq("R4", "busy low with done", busy, 0);
    @(negedge clk);
    check_eq("R4", "done lasts one clock", frame_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired, all requirements R1 through end unverified");
    finish_up();
  end

  initial begin
    tick(5);
    rst = 1'b0;
    px_valid = 1'b1;
    tick(1);
    check_eq("R3", "reset cs_n", cs_n, 1);
    check_eq("R3", "reset wr_n", wr_n, 1);
    check_eq("R4", "reset busy", busy, 0);
    check_eq("R4", "reset done", frame_done, 0);
    check_eq("R7", "reset command bit", sw_trig_bit, 0);

    // R1 R2: sweep of every count combination over {0,1,2,15}
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int m = 0; m < 4; m++)
          for (int n = 0; n < 4; n++) begin
            int k;
            k = ((i * 4 + j) * 4 + m) * 4 + n;
            run_frame(tv(i), tv(j), tv(m), tv(n), 1 + (k % 3), 1, "R1");
          end

    // R4: multi-line frame and an empty frame
    run_frame(0, 1, 0, 2, 3, 2, "R4");
    run_frame(1, 1, 1, 1, 0, 5, "R4");

    // R6: trigger mode off
    set_timing(0, 0, 0, 0, 1'b1);
    frame_w = 1; frame_h = 1;
    trig_cfg = 32'h0;
    pulse_sw();
    tick(5);
    check_eq("R6", "no start with mode off", busy, 0);
    check_eq("R6", "command not recorded", sw_trig_bit, 0);

    // R5: interface disabled holds the command, enabling starts the frame
    set_timing(0, 0, 0, 0, 1'b0);
    trig_cfg = 32'h1;
    pulse_sw();
    tick(5);
    check_eq("R5", "no start while disabled", busy, 0);
    check_eq("R5", "command kept pending", sw_trig_bit, 1);
    check_eq("R5", "no cycles while disabled", cs_n, 1);
    set_timing(0, 0, 0, 0, 1'b1);
    @(negedge clk);
    check_eq("R5", "start once enabled", busy, 1);
    wait_done("R5");
    tick(2);

    // R7: software command timing
    pulse_sw();
    check_eq("R7", "command bit set", sw_trig_bit, 1);
    check_eq("R7", "not yet busy", busy, 0);
    @(negedge clk);
    check_eq("R7", "busy next clock", busy, 1);
    check_eq("R7", "command bit cleared", sw_trig_bit, 0);
    wait_done("R7");
    tick(2);

    // R11: pulses during a running frame are dropped
    set_timing(2, 2, 2, 2, 1'b1);
    frame_w = 3;
    pulse_sw();
    tick(6);
    pulse_sw();
    check_eq("R11", "mid-frame command dropped", sw_trig_bit, 0);
    pulse_te();
    wait_done("R11");
    tick(8);
    check_eq("R11", "no extra frame", busy, 0);

    // R11: software pulse on the completion clock
    set_timing(1, 0, 1, 0, 1'b1);
    frame_w = 1;
    pulse_sw();
    @(negedge clk);
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    sw_trig_wr = 1'b1;
    @(negedge clk);
    sw_trig_wr = 1'b0;
    check_eq("R11", "done on coincident clock", frame_done, 1);
    @(negedge clk);
    check_eq("R11", "coincident command dropped", sw_trig_bit, 0);
    tick(6);
    check_eq("R11", "no restart after coincident command", busy, 0);

    // R8: every edge triggers
    trig_cfg = 32'h8000_0009;
    pulse_te();
    check_eq("R8", "edge starts frame", busy, 1);
    wait_done("R8");
    tick(3);
    pulse_te();
    check_eq("R8", "second edge starts frame", busy, 1);
    // R11: edge on the completion clock
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    te_in = 1'b1;
    @(negedge clk);
    te_in = 1'b0;
    check_eq("R11", "done with coincident edge", frame_done, 1);
    tick(6);
    check_eq("R11", "coincident edge dropped", busy, 0);

    // R10: masked edges, software starts directly
    trig_cfg = 32'h8000_0019;
    pulse_te();
    tick(4);
    check_eq("R10", "masked edge ignored", busy, 0);
    pulse_sw();
    @(negedge clk);
    check_eq("R10", "software starts when masked", busy, 1);
    wait_done("R10");
    tick(3);

    // R9: edge needs a pending command
    trig_cfg = 32'h0000_0009;
    pulse_te();
    tick(4);
    check_eq("R9", "edge alone ignored", busy, 0);
    pulse_sw();
    tick(5);
    check_eq("R9", "command alone waits", busy, 0);
    check_eq("R9", "command still pending", sw_trig_bit, 1);
    pulse_te();
    check_eq("R9", "edge with command starts", busy, 1);
    check_eq("R9", "command consumed", sw_trig_bit, 0);
    wait_done("R9");
    tick(4);

    finish_up();
  end

endmodule